// File: doc/BRIEF.md
# Low-Power Real-Time Clock with Handshaked Register Writes

This block is a seconds-and-fraction real-time clock. A 47-bit time counter advances once for every pulse of a slow tick (a 32 kHz enable in the fast bus clock domain). The upper 32 bits are whole seconds and the lower 15 bits are the sub-second fraction. A seconds alarm comparator raises a sticky flag. A status register collects the sticky flags, an interrupt-enable register masks them, and one interrupt output reports any enabled flag.

Software uses a 32-bit register port. A write to any register except interrupt-enable is held as a single pending write. It takes effect on the next tick pulse, and at that point the write-complete flag is raised. While the write waits, a busy flag is visible. A second write during that time is dropped and flags a write error. Interrupt-enable writes skip the handshake and take effect on the next bus clock edge.

Top module: `lp_rtc`

## Requirements
- R1: After reset, status reads 0x0000_0202 (not-valid flag at bit 1, write-ready at bit 9, all others clear), interrupt-enable, control and alarm fraction read 0, alarm seconds reads all ones, time registers read 0 and `irq` is low.
- R2: A write to seconds (0x00), fraction (0x04), alarm seconds (0x08), alarm fraction (0x0C), control (0x10) or status (0x14) sets busy (status bit 10) and clears write-ready (bit 9) from the next clock edge. The write changes no register until the first clock edge on which `tick` is high. On that edge the target register is updated, busy clears and write-complete (bit 8) sets.
- R3: A write to interrupt-enable (0x18) is visible on the next clock edge and sets neither busy nor write-complete. Only bits 9, 8, 7 and 4 are stored.
- R4: A read of status clears write-complete after that read, and leaves every other status bit unchanged.
- R5: A handshaked write issued while busy is discarded and sets write-error (status bit 7). The pending write still completes with its own value.
- R6: A status write with ones at bit 7, 4, 1 or 0 clears the matching flag once it has been applied. Zeros leave flags unchanged.
- R7: The time counter adds one on each tick edge, but only while control bit 3 is set and the time has been written at least once. Seconds reads counter bits 46:15 at 0x00, and fraction reads counter bits 14:0 in data bits 14:0 at 0x04. Before the first time write, both read 0 and the counter does not run.
- R8: The alarm flag (status bit 4) is set on every clock edge on which counter seconds equals alarm seconds, unless alarm seconds is all ones. Alarm fraction stores data bits 14:0 and reads them back, but it is not compared.
- R9: `irq` is high exactly when some status bit among 9, 8, 7 and 4 is set together with the same bit of interrupt-enable.
- R10: Control stores only bit 3. Other control bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-cycle slow-domain tick enable |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (status read side effect) |
| addr | input | 5 | Byte address, bits 4:2 decoded |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` (combinational) |
| irq | output | 1 | Interrupt request |

## Verification
The hardest conditions to reach are the ones that depend on the slow tick relative to bus activity. Examples are a second write arriving inside the busy window, a time load that replaces an increment on the same tick, and a seconds rollover that lands exactly on the alarm value. The bench drives `tick` itself, one pulse per call, so every write can be placed before, inside or after a busy window. Random seconds and fraction values, with fractions biased toward 0x7FFF, make carries into the seconds field common. A bench model predicts the counter value and each flag.

// File: rtl/lp_rtc_pkg.sv
package lp_rtc_pkg;
  // register indices (addr[4:2])
  localparam logic [2:0] RG_SEC  = 3'd0;
  localparam logic [2:0] RG_FRAC = 3'd1;
  localparam logic [2:0] RG_ASEC = 3'd2;
  localparam logic [2:0] RG_AFRC = 3'd3;
  localparam logic [2:0] RG_CTRL = 3'd4;
  localparam logic [2:0] RG_STAT = 3'd5;
  localparam logic [2:0] RG_IEN  = 3'd6;

  // status / enable bit positions
  localparam int B_BUSY = 10;
  localparam int B_RDY  = 9;
  localparam int B_DONE = 8;
  localparam int B_ERR  = 7;
  localparam int B_ALM  = 4;
  localparam int B_NV   = 1;
  localparam int B_SV   = 0;
  localparam int B_RUN  = 3;

  localparam logic [31:0] IEN_MASK = (32'd1 << B_RDY) | (32'd1 << B_DONE)
                                   | (32'd1 << B_ERR) | (32'd1 << B_ALM);

  function automatic logic is_handshaked(input logic [2:0] idx);
    return (idx <= RG_STAT);
  endfunction

  function automatic logic irq_of(input logic [31:0] st, input logic [31:0] en);
    return |(st & en & IEN_MASK);
  endfunction
endpackage

// File: rtl/lp_rtc_sync.sv
module lp_rtc_sync #(
  parameter int DW = 32,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          req,
  input  logic [AW-1:0] req_idx,
  input  logic [DW-1:0] req_data,
  output logic          busy,
  output logic          apply_stb,
  output logic          drop_stb,
  output logic [AW-1:0] ap_idx,
  output logic [DW-1:0] ap_data
);
  assign apply_stb = busy && tick;
  assign drop_stb  = busy && req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      ap_idx  <= '0;
      ap_data <= '0;
    end else if (apply_stb) begin
      busy <= 1'b0;
    end else if (req && !busy) begin
      busy    <= 1'b1;
      ap_idx  <= req_idx;
      ap_data <= req_data;
    end
  end
endmodule

// File: rtl/lp_rtc_counter.sv
module lp_rtc_counter #(
  parameter int SEC_W  = 32,
  parameter int FRAC_W = 15,
  localparam int CNT_W = SEC_W + FRAC_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             run_en,
  input  logic             load_sec,
  input  logic             load_frac,
  input  logic [SEC_W-1:0] load_val,
  input  logic [SEC_W-1:0] alarm_sec,
  output logic [CNT_W-1:0] cnt,
  output logic             written,
  output logic             alarm_hit
);
  localparam logic [SEC_W-1:0] NO_ALARM = '1;

  function automatic logic [CNT_W-1:0] advance(input logic [CNT_W-1:0] c);
    return c + CNT_W'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      written <= 1'b0;
    end else if (load_sec) begin
      cnt[CNT_W-1:FRAC_W] <= load_val;
      written             <= 1'b1;
    end else if (load_frac) begin
      cnt[FRAC_W-1:0] <= load_val[FRAC_W-1:0];
      written         <= 1'b1;
    end else if (tick && run_en && written) begin
      cnt <= advance(cnt);
    end
  end

  assign alarm_hit = (alarm_sec != NO_ALARM) && (cnt[CNT_W-1:FRAC_W] == alarm_sec);
endmodule

// File: rtl/lp_rtc.sv
module lp_rtc
  import lp_rtc_pkg::*;
#(
  parameter int SEC_W  = 32,
  parameter int FRAC_W = 15
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic [4:0]  addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic        irq
);
  localparam int CNT_W = SEC_W + FRAC_W;

  logic [2:0]       idx;
  logic             hs_req, busy, apply_stb, drop_stb;
  logic [2:0]       ap_idx;
  logic [31:0]      ap_data;
  logic [CNT_W-1:0] cnt;
  logic             written, alarm_hit;
  logic [SEC_W-1:0] alarm_sec;
  logic [FRAC_W-1:0] alarm_frac;
  logic             run_q;
  logic             wc, we_flag, af, nv, sv;
  logic [31:0]      ien;
  logic [31:0]      status;
  logic             ap_sec, ap_frac, ap_asec, ap_afrc, ap_ctrl, ap_stat;
  logic             stat_rd;

  assign idx     = addr[4:2];
  assign hs_req  = wr_en && is_handshaked(idx);
  assign stat_rd = rd_en && (idx == RG_STAT);

  lp_rtc_sync #(.DW(32), .AW(3)) u_sync (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .req(hs_req), .req_idx(idx), .req_data(wdata),
    .busy(busy), .apply_stb(apply_stb), .drop_stb(drop_stb),
    .ap_idx(ap_idx), .ap_data(ap_data)
  );

  assign ap_sec  = apply_stb && (ap_idx == RG_SEC);
  assign ap_frac = apply_stb && (ap_idx == RG_FRAC);
  assign ap_asec = apply_stb && (ap_idx == RG_ASEC);
  assign ap_afrc = apply_stb && (ap_idx == RG_AFRC);
  assign ap_ctrl = apply_stb && (ap_idx == RG_CTRL);
  assign ap_stat = apply_stb && (ap_idx == RG_STAT);

  lp_rtc_counter #(.SEC_W(SEC_W), .FRAC_W(FRAC_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .run_en(run_q),
    .load_sec(ap_sec), .load_frac(ap_frac), .load_val(ap_data[SEC_W-1:0]),
    .alarm_sec(alarm_sec), .cnt(cnt), .written(written), .alarm_hit(alarm_hit)
  );

  // slow-path configuration registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alarm_sec  <= '1;
      alarm_frac <= '0;
      run_q      <= 1'b0;
    end else begin
      if (ap_asec) alarm_sec  <= ap_data[SEC_W-1:0];
      if (ap_afrc) alarm_frac <= ap_data[FRAC_W-1:0];
      if (ap_ctrl) run_q      <= ap_data[B_RUN];
    end
  end

  // interrupt enable: bus-speed path
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ien <= '0;
    else if (wr_en && idx == RG_IEN) ien <= wdata & IEN_MASK;
  end

  // sticky flags; set has priority over clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wc <= 1'b0; we_flag <= 1'b0; af <= 1'b0; nv <= 1'b1; sv <= 1'b0;
    end else begin
      if (apply_stb)      wc <= 1'b1;
      else if (stat_rd)   wc <= 1'b0;
      if (drop_stb)                     we_flag <= 1'b1;
      else if (ap_stat && ap_data[B_ERR]) we_flag <= 1'b0;
      if (alarm_hit)                    af <= 1'b1;
      else if (ap_stat && ap_data[B_ALM]) af <= 1'b0;
      if (ap_stat && ap_data[B_NV]) nv <= 1'b0;
      if (ap_stat && ap_data[B_SV]) sv <= 1'b0;
    end
  end

  always_comb begin
    status = '0;
    status[B_BUSY] = busy;
    status[B_RDY]  = !busy;
    status[B_DONE] = wc;
    status[B_ERR]  = we_flag;
    status[B_ALM]  = af;
    status[B_NV]   = nv;
    status[B_SV]   = sv;
  end

  always_comb begin
    rdata = '0;
    case (idx)
      RG_SEC:  if (written) rdata[SEC_W-1:0]  = cnt[CNT_W-1:FRAC_W];
      RG_FRAC: if (written) rdata[FRAC_W-1:0] = cnt[FRAC_W-1:0];
      RG_ASEC: rdata[SEC_W-1:0]  = alarm_sec;
      RG_AFRC: rdata[FRAC_W-1:0] = alarm_frac;
      RG_CTRL: rdata[B_RUN] = run_q;
      RG_STAT: rdata = status;
      RG_IEN:  rdata = ien;
      default: rdata = '0;
    endcase
  end

  assign irq = irq_of(status, ien);
endmodule

// File: rtl/lp_rtc_chk.sv
module lp_rtc_chk #(
  parameter int CNT_W = 47
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             wr_en,
  input logic             rd_en,
  input logic [4:0]       addr,
  input logic             busy,
  input logic             apply_stb,
  input logic             drop_stb,
  input logic             wc,
  input logic             we_flag,
  input logic             af,
  input logic             alarm_hit,
  input logic             ien_alarm,
  input logic             irq,
  input logic [CNT_W-1:0] cnt
);
  p_busy_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tick) |=> busy);
  p_apply_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
    apply_stb |=> wc);
  p_ien_bypass_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr[4:2] == 3'd6 && !busy) |=> !busy);
  p_read_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr[4:2] == 3'd5 && !apply_stb) |=> !wc);
  p_drop_err_r5: assert property (@(posedge clk) disable iff (!rst_n)
    drop_stb |=> we_flag);
  p_cnt_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt));
  p_alarm_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_hit |=> af);
  p_alarm_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm_hit && ien_alarm && !(wr_en && addr[4:2] == 3'd6)) |=> irq);
endmodule

bind lp_rtc lp_rtc_chk #(.CNT_W(SEC_W + FRAC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .rd_en(rd_en),
  .addr(addr), .busy(busy), .apply_stb(apply_stb), .drop_stb(drop_stb),
  .wc(wc), .we_flag(we_flag), .af(af), .alarm_hit(alarm_hit),
  .ien_alarm(ien[4]), .irq(irq), .cnt(cnt)
);

// File: tb/tb_lp_rtc.sv
module tb_lp_rtc;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  // bench model of the counter
  logic [46:0] m_cnt = '0;
  bit          m_wr = 0;
  bit          m_en = 0;

  lp_rtc dut (.clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .rd_en(rd_en),
              .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq));

  always #2 clk = ~clk;

  function automatic logic [46:0] m_step(input logic [46:0] c, input int n);
    logic [46:0] r = c;
    for (int k = 0; k < n; k++) r = r + 47'd1;
    return r;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    #1 d = rdata;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  // one tick pulse; model counts unless a time load replaces it
  task automatic do_tick(input bit time_load);
    tick = 1'b1;
    if (!time_load && m_en && m_wr) m_cnt = m_step(m_cnt, 1);
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic sync_wr(input logic [4:0] a, input logic [31:0] d);
    bit tl;
    tl = (a == 5'h00) || (a == 5'h04);
    bus_wr(a, d);
    do_tick(tl);
    if (a == 5'h00) begin m_cnt[46:15] = d; m_wr = 1; end
    if (a == 5'h04) begin m_cnt[14:0] = d[14:0]; m_wr = 1; end
    if (a == 5'h10) m_en = d[3];
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'd0, 32'd1);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [31:0] s;
    logic [14:0] f;
    int n;
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    bus_rd(5'h14, d); chk("R1 status", d, 32'h0000_0202);
    bus_rd(5'h18, d); chk("R1 ien", d, 0);
    bus_rd(5'h10, d); chk("R1 ctrl", d, 0);
    bus_rd(5'h08, d); chk("R1 alarm sec", d, 32'hFFFF_FFFF);
    bus_rd(5'h0C, d); chk("R1 alarm frac", d, 0);
    bus_rd(5'h00, d); chk("R1 sec", d, 0);
    chk("R1 irq", {31'd0, irq}, 0);

    // R10 control bits; R7 no count before first time write
    sync_wr(5'h10, 32'hFFFF_FFFF);
    bus_rd(5'h10, d); chk("R10 ctrl readback", d, 32'h8);
    bus_rd(5'h14, d); // clear done
    repeat (5) do_tick(0);
    bus_rd(5'h00, d); chk("R7 sec before write", d, 0);
    bus_rd(5'h04, d); chk("R7 frac before write", d, 0);

    // R2 busy window and completion
    bus_wr(5'h0C, 32'hABCD_1234);
    bus_rd(5'h14, d); chk("R2 busy set", d & 32'h700, 32'h400);
    bus_rd(5'h0C, d); chk("R2 not yet applied", d, 0);
    do_tick(0);
    bus_rd(5'h0C, d); chk("R8 alarm frac readback", d, 32'h1234);
    bus_rd(5'h14, d); chk("R2 done after tick", d & 32'h700, 32'h300);
    bus_rd(5'h14, d); chk("R4 done cleared by read", d & 32'h700, 32'h200);
    chk("R4 other bits kept", d & 32'h93, 32'h2);

    // R3 interrupt-enable bypass
    bus_wr(5'h18, 32'hFFFF_FFFF);
    bus_rd(5'h18, d); chk("R3 ien immediate", d, 32'h390);
    bus_rd(5'h14, d); chk("R3 no busy/done", d & 32'h500, 0);
    chk("R9 irq from ready", {31'd0, irq}, 1);
    bus_wr(5'h18, 32'h0);
    chk("R9 irq masked", {31'd0, irq}, 0);

    // R5 write while busy
    bus_wr(5'h08, 32'h1000);
    bus_wr(5'h08, 32'h2000);
    do_tick(0);
    bus_rd(5'h08, d); chk("R5 first write kept", d, 32'h1000);
    bus_rd(5'h14, d); chk("R5 error flag", d & 32'h80, 32'h80);
    bus_wr(5'h18, 32'h80);
    chk("R9 irq on error", {31'd0, irq}, 1);
    sync_wr(5'h14, 32'h80);
    bus_rd(5'h14, d); chk("R6 error cleared", d & 32'h80, 0);
    sync_wr(5'h14, 32'h2);
    bus_rd(5'h14, d); chk("R6 not-valid cleared", d & 32'h2, 0);
    sync_wr(5'h08, 32'hFFFF_FFFF);
    bus_wr(5'h18, 32'h0);

    // R7 random counting, fractions biased toward carry
    for (int i = 0; i < 16; i++) begin
      s = $urandom;
      if (s == 32'hFFFF_FFFF) s = 32'h1;
      f = (i % 3 == 0) ? 15'(15'h7FFF - 15'($urandom_range(0, 6))) : 15'($urandom);
      n = $urandom_range(0, 20);
      sync_wr(5'h04, {17'd0, f});
      sync_wr(5'h00, s);
      repeat (n) do_tick(0);
      bus_rd(5'h00, d); chk("R7 seconds", d, m_cnt[46:15]);
      bus_rd(5'h04, d); chk("R7 fraction", d, {17'd0, m_cnt[14:0]});
    end

    // R8 alarm on seconds carry, R9 irq
    bus_rd(5'h14, d);
    sync_wr(5'h04, 32'h7FFE);
    sync_wr(5'h00, 32'h0000_0100);
    sync_wr(5'h08, 32'h0000_0101);
    bus_rd(5'h14, d); chk("R8 no alarm before", d & 32'h10, 0);
    bus_wr(5'h18, 32'h10);
    do_tick(0);
    bus_rd(5'h00, d); chk("R8 seconds reached", d, 32'h101);
    bus_rd(5'h14, d); chk("R8 alarm flag", d & 32'h10, 32'h10);
    chk("R9 irq alarm", {31'd0, irq}, 1);
    sync_wr(5'h08, 32'hFFFF_FFFF);
    sync_wr(5'h14, 32'h10);
    bus_rd(5'h14, d); chk("R6 alarm cleared", d & 32'h10, 0);
    chk("R9 irq low", {31'd0, irq}, 0);
    bus_rd(5'h04, d); chk("R7 fraction after carry", d, {17'd0, m_cnt[14:0]});

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule